// File: doc/BRIEF.md
# Bang-bang phase decision and loop filter for clock and data recovery

This block is the digital core of a bang-bang clock and data recovery loop. Each bit period it is handed three samples of the incoming stream: one at the centre of the current bit (A), one near the following edge (T) and one at the centre of the next bit (B). From these it decides whether the local clock is early, late or cannot be judged. It then emits a single-cycle up or down pulse and presents the A sample as the recovered data bit.

The decisions drive two loop paths. The integral path adds or subtracts a programmable step into a signed, saturating centre-frequency word. The proportional path adds a fixed offset of +K or -K to that word for the one cycle a pulse is present. The sum is the oscillator control word. A freeze input, driven by an external frequency acquisition block while the oscillator is outside its window, stops all decisions so that neither path moves.

Top module: `bangbang_loop`

## Requirements
- R1: When a valid triple has A equal to B, no up and no down pulse follows in the next cycle, whatever T is.
- R2: When a valid triple has A equal to T and B different, dn_o is 1 and up_o is 0 in the cycle after the triple is presented (clock early).
- R3: When a valid triple has B equal to T and A different, up_o is 1 and dn_o is 0 in the cycle after the triple is presented (clock late).
- R4: data_o equals the A sample of the most recent valid triple, from the cycle after it is presented; it holds while valid_i is 0.
- R5: A pulse lasts exactly one cycle unless the next cycle also presents a triple with the same decision; a cycle with valid_i at 0 gives no pulse in the following cycle.
- R6: While freeze_i is 1 no pulse is produced and the centre-frequency word does not change; data_o is still updated.
- R7: In the cycle after up_o is 1 the centre-frequency word has grown by ki_i; after dn_o it has shrunk by ki_i; with no pulse it is unchanged.
- R8: The centre-frequency word saturates at lim_hi_i and lim_lo_i (signed, two's complement) instead of wrapping.
- R9: ctrl_word_o is the sign-extended centre-frequency word plus kp_i while up_o is 1, minus kp_i while dn_o is 1, and equal to it otherwise.
- R10: After reset up_o, dn_o and data_o are 0 and the centre-frequency word and ctrl_word_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A sample triple is present this cycle |
| samp_a_i | input | 1 | Sample at the current bit centre |
| samp_t_i | input | 1 | Sample near the following edge |
| samp_b_i | input | 1 | Sample at the next bit centre |
| freeze_i | input | 1 | Frequency fault: suppress decisions |
| kp_i | input | KP_W | Proportional offset K |
| ki_i | input | KI_W | Integral step per pulse |
| lim_hi_i | input | INT_W | Upper saturation limit, signed |
| lim_lo_i | input | INT_W | Lower saturation limit, signed |
| up_o | output | 1 | Clock late: speed up |
| dn_o | output | 1 | Clock early: slow down |
| data_o | output | 1 | Recovered data bit |
| freq_word_o | output | INT_W | Centre-frequency word, signed |
| ctrl_word_o | output | INT_W+1 | Oscillator control word, signed |

## Verification
The bench walks all eight sample combinations, with and without freeze, so a detector that swapped the early and late cases, acted on a T disagreement when A equals B, or ignored freeze would show the wrong pulse. It drives trains of same-direction pulses into tight limits, where an accumulator that wrapped instead of clamping would jump to the opposite sign. It checks that a pulse ends after one cycle when valid_i drops and that data_o holds, which catches a decision register left stuck, and it checks the control word during and after each pulse, catching an offset of the wrong sign or one applied a cycle late.

// File: rtl/bbl_pkg.sv
package bbl_pkg;
  typedef enum logic [1:0] {DEC_NONE = 2'd0, DEC_UP = 2'd1, DEC_DN = 2'd2} dec_e;

  // three-sample early/late rule
  function automatic dec_e classify(input logic a, input logic t, input logic b);
    if (a == b)      return DEC_NONE;
    else if (a == t) return DEC_DN;
    else             return DEC_UP;
  endfunction
endpackage

// File: rtl/bbl_decider.sv
module bbl_decider
  import bbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic a_i,
  input  logic t_i,
  input  logic b_i,
  input  logic freeze_i,
  output logic up_o,
  output logic dn_o,
  output logic data_o
);
  dec_e dec;
  logic act;

  assign dec = classify(a_i, t_i, b_i);
  assign act = valid_i && !freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o   <= 1'b0;
      dn_o   <= 1'b0;
      data_o <= 1'b0;
    end else begin
      up_o <= act && (dec == DEC_UP);
      dn_o <= act && (dec == DEC_DN);
      if (valid_i) data_o <= a_i;
    end
  end

  assert_no_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_i == b_i) |=> (!up_o && !dn_o));
  assert_early_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && a_i == t_i && b_i != t_i) |=> (dn_o && !up_o));
  assert_late_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && b_i == t_i && a_i != t_i) |=> (up_o && !dn_o));
  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  assert_idle_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!up_o && !dn_o));
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> (!up_o && !dn_o));
endmodule

// File: rtl/bbl_integrator.sv
module bbl_integrator #(
  parameter int INT_W = 16,
  parameter int KI_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    up_i,
  input  logic                    dn_i,
  input  logic [KI_W-1:0]         ki_i,
  input  logic signed [INT_W-1:0] lim_hi_i,
  input  logic signed [INT_W-1:0] lim_lo_i,
  output logic signed [INT_W-1:0] acc_o
);
  localparam int EXT_W = INT_W + 2;

  logic signed [EXT_W-1:0] acc_x, step_x, sum_x, hi_x, lo_x;
  logic signed [INT_W-1:0] acc_d;

  assign acc_x  = EXT_W'(acc_o);
  assign step_x = $signed({{(EXT_W-KI_W){1'b0}}, ki_i});
  assign hi_x   = EXT_W'(lim_hi_i);
  assign lo_x   = EXT_W'(lim_lo_i);

  always_comb begin
    if (up_i)      sum_x = acc_x + step_x;
    else if (dn_i) sum_x = acc_x - step_x;
    else           sum_x = acc_x;
    if (sum_x > hi_x)      acc_d = lim_hi_i;
    else if (sum_x < lo_x) acc_d = lim_lo_i;
    else                   acc_d = sum_x[INT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_o <= '0;
    else if (up_i || dn_i)  acc_o <= acc_d;
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i) |=> $stable(acc_o));
  assert_sat_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && lim_lo_i <= lim_hi_i && acc_o <= lim_hi_i) |=> (acc_o <= $past(lim_hi_i)));
  assert_sat_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && lim_lo_i <= lim_hi_i && acc_o >= lim_lo_i) |=> (acc_o >= $past(lim_lo_i)));
endmodule

// File: rtl/bbl_ctrl_mix.sv
module bbl_ctrl_mix #(
  parameter int INT_W = 16,
  parameter int KP_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  up_i,
  input  logic                  dn_i,
  input  logic [KP_W-1:0]       kp_i,
  input  logic signed [INT_W-1:0] acc_i,
  output logic signed [INT_W:0] ctrl_o
);
  localparam int CW = INT_W + 1;

  logic signed [CW-1:0] base, kp_x;

  assign base = CW'(acc_i);
  assign kp_x = $signed({{(CW-KP_W){1'b0}}, kp_i});

  always_comb begin
    if (up_i)      ctrl_o = base + kp_x;
    else if (dn_i) ctrl_o = base - kp_x;
    else           ctrl_o = base;
  end

  assert_no_offset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i) |-> (ctrl_o == CW'(acc_i)));
endmodule

// File: rtl/bangbang_loop.sv
module bangbang_loop #(
  parameter int INT_W = 16,
  parameter int KP_W  = 8,
  parameter int KI_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    samp_a_i,
  input  logic                    samp_t_i,
  input  logic                    samp_b_i,
  input  logic                    freeze_i,
  input  logic [KP_W-1:0]         kp_i,
  input  logic [KI_W-1:0]         ki_i,
  input  logic signed [INT_W-1:0] lim_hi_i,
  input  logic signed [INT_W-1:0] lim_lo_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic                    data_o,
  output logic signed [INT_W-1:0] freq_word_o,
  output logic signed [INT_W:0]   ctrl_word_o
);
  bbl_decider u_dec (
    .clk_i, .rst_ni, .valid_i,
    .a_i(samp_a_i), .t_i(samp_t_i), .b_i(samp_b_i),
    .freeze_i, .up_o, .dn_o, .data_o
  );

  bbl_integrator #(.INT_W(INT_W), .KI_W(KI_W)) u_int (
    .clk_i, .rst_ni, .up_i(up_o), .dn_i(dn_o), .ki_i,
    .lim_hi_i, .lim_lo_i, .acc_o(freq_word_o)
  );

  bbl_ctrl_mix #(.INT_W(INT_W), .KP_W(KP_W)) u_mix (
    .clk_i, .rst_ni, .up_i(up_o), .dn_i(dn_o), .kp_i,
    .acc_i(freq_word_o), .ctrl_o(ctrl_word_o)
  );

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up_o, dn_o}));
endmodule

// File: tb/bangbang_loop_bench.sv
module bangbang_loop_bench;
  localparam int INT_W = 16;
  localparam int KP_W  = 8;
  localparam int KI_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid, a, t, b, frz;
  logic [KP_W-1:0] kp;
  logic [KI_W-1:0] ki;
  logic signed [INT_W-1:0] lim_hi, lim_lo;
  logic up, dn, data;
  logic signed [INT_W-1:0] freq;
  logic signed [INT_W:0] ctrl;

  int checks = 0, errors = 0;
  int model = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bangbang_loop #(.INT_W(INT_W), .KP_W(KP_W), .KI_W(KI_W)) u_bangbang_loop (
    .clk_i(clk), .rst_ni, .valid_i(valid), .samp_a_i(a), .samp_t_i(t),
    .samp_b_i(b), .freeze_i(frz), .kp_i(kp), .ki_i(ki),
    .lim_hi_i(lim_hi), .lim_lo_i(lim_lo), .up_o(up), .dn_o(dn),
    .data_o(data), .freq_word_o(freq), .ctrl_word_o(ctrl)
  );

  // {a, t, b, freeze, exp_up, exp_dn, exp_data}
  localparam logic [6:0] VEC [12] = '{
    7'b000_0_000, 7'b010_0_000, 7'b101_0_001, 7'b111_0_001,
    7'b001_0_010, 7'b110_0_011, 7'b011_0_100, 7'b100_0_101,
    7'b011_1_000, 7'b100_1_001, 7'b011_0_100, 7'b011_0_100
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // call at negedge after a posedge; checks pulse outputs and loop words
  task automatic check_loop(input string tag, input bit eu, input bit ed);
    chk({tag, " up"}, int'(up), int'(eu));
    chk({tag, " dn"}, int'(dn), int'(ed));
    chk({"R7 freq ", tag}, int'(freq), model);
    chk({"R9 ctrl ", tag}, int'(ctrl), model + (eu ? int'(kp) : 0) - (ed ? int'(kp) : 0));
    if (eu) model = model + int'(ki);
    if (ed) model = model - int'(ki);
    if (model > int'(lim_hi)) model = int'(lim_hi);
    if (model < int'(lim_lo)) model = int'(lim_lo);
  endtask

  task automatic drive(input bit v, input bit ia, input bit it, input bit ib, input bit f);
    valid = v; a = ia; t = it; b = ib; frz = f;
    @(negedge clk);
  endtask

  initial begin
    valid = 0; a = 0; t = 0; b = 0; frz = 0;
    kp = 8'd4; ki = 8'd1; lim_hi = 16'sd1000; lim_lo = -16'sd1000;
    repeat (3) @(negedge clk);
    chk("R10 up", int'(up), 0);
    chk("R10 dn", int'(dn), 0);
    chk("R10 data", int'(data), 0);
    chk("R10 freq", int'(freq), 0);
    chk("R10 ctrl", int'(ctrl), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // vector walk
    for (int i = 0; i < 12; i++) begin
      string tag;
      logic [6:0] v;
      v = VEC[i];
      if (v[3]) tag = "R6";
      else if (v[6] == v[4]) tag = "R1";
      else if (v[2]) tag = "R3";
      else tag = "R2";
      drive(1, v[6], v[5], v[4], v[3]);
      check_loop($sformatf("%s vec%0d", tag, i), v[2], v[1]);
      chk($sformatf("R4 data vec%0d", i), int'(data), int'(v[0]));
    end

    // valid drops: pulse ends, data holds
    drive(0, 0, 1, 1, 0);
    check_loop("R5 gap", 0, 0);
    chk("R4 hold", int'(data), 0);
    drive(1, 1, 0, 0, 0);
    check_loop("R3 after gap", 1, 0);
    drive(0, 0, 0, 1, 0);
    check_loop("R5 single", 0, 0);
    chk("R4 hold one", int'(data), 1);

    // freeze: data still captured, freq untouched
    drive(1, 1, 1, 0, 1);
    check_loop("R6 frz dn", 0, 0);
    chk("R6 data", int'(data), 1);
    drive(0, 0, 0, 0, 0);
    check_loop("R6 after", 0, 0);

    // saturation high
    ki = 8'd2; lim_hi = 16'sd5; lim_lo = -16'sd3;
    for (int i = 0; i < 5; i++) begin
      drive(1, 0, 1, 1, 0);
      check_loop($sformatf("R8 hi%0d", i), 1, 0);
    end
    drive(0, 0, 0, 0, 0);
    check_loop("R8 hi end", 0, 0);
    chk("R8 at hi", int'(freq), 5);

    // saturation low
    for (int i = 0; i < 7; i++) begin
      drive(1, 1, 1, 0, 0);
      check_loop($sformatf("R8 lo%0d", i), 0, 1);
    end
    drive(0, 0, 0, 0, 0);
    check_loop("R8 lo end", 0, 0);
    chk("R8 at lo", int'(freq), -3);

    // large proportional offset
    kp = 8'd200; ki = 8'd0;
    drive(1, 1, 0, 0, 0);
    check_loop("R9 big up", 1, 0);
    drive(1, 0, 0, 1, 0);
    check_loop("R9 big dn", 0, 1);
    drive(0, 0, 0, 0, 0);
    check_loop("R9 idle", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule